// File: doc/BRIEF.md
# Lane PRBS Error Checker

This block watches one receive lane, delivered as a parallel word per valid cycle, and measures how well it carries a pseudo-random test pattern. A local copy of the pattern is predicted from a 31-bit bit history using the recurrence of the selected polynomial. Until the pattern is acquired, the history is filled from the received bits themselves. After enough clean bits the block declares lock. From then on the history advances from its own predictions, so every corrupted received bit counts as exactly one error.

Errors go into two saturating counters. The first is a running total since the last clear. The second is a snapshot that is taken on each one-second tick from a working count, which then starts again from zero. A configurable polarity setting complements the received data before comparison. The one-second tick comes from outside the block. Heavy error bursts drop the lock, and the block then returns to reseeding from the line.

Top module: `prbs_lane_checker`

## Requirements
- R1: Polynomial select encodings are 0: b[n]=b[n-7]^b[n-6], 1: b[n]=b[n-15]^b[n-14], 2: b[n]=b[n-23]^b[n-18], 3: b[n]=b[n-31]^b[n-28]. Bit W-1 of a word is the earliest bit on the line. While unlocked, each received bit enters the history. Lock is declared at the end of the word that completes LOCK_BITS (64) consecutive error-free bits, counted in whole words. A word with any mismatch restarts the run.
- R2: When invert is 1, received bits are complemented before prediction and comparison. Complemented data therefore locks only with invert set.
- R3: Errors are counted only during words that arrive while locked, and each mismatching bit adds one. Mismatches while unlocked never reach either counter.
- R4: Windows of WIN_BITS (64) bits start at the word after lock is declared. Lock is lost at the end of the word that takes the window's error count above LOSS_ERRS (16), and that word's errors are counted. Exactly LOSS_ERRS errors in a window keep lock.
- R5: err_total holds the sum of all counted errors since the last clear or reset.
- R6: On a cycle with tick_1s high, err_last_sec takes the working count plus the current word's counted errors, and the working count restarts at zero. Otherwise err_last_sec holds its value. A tick without valid data still takes the snapshot.
- R7: clear zeroes err_total, err_last_sec and the working count, and it takes priority over errors and tick in the same cycle. It does not affect lock.
- R8: Both counters saturate at 2^CNT_W-1 rather than wrapping.
- R9: While rx_valid is low, neither the lock state, the history nor err_total changes.
- R10: After synchronous active-low reset, locked is 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | W | Received lane word, MSB earliest |
| rx_valid | input | 1 | rx_data holds a word this cycle |
| poly_sel | input | 2 | Polynomial choice (encoding in R1) |
| invert | input | 1 | Complement received data before checking |
| clear | input | 1 | Zero both counters |
| tick_1s | input | 1 | One-second boundary pulse |
| locked | output | 1 | Pattern acquired |
| err_total | output | CNT_W | Errors since last clear |
| err_last_sec | output | CNT_W | Errors in the last completed second |

## Verification
A history that is corrupted while locked never heals itself, because the predictor free-runs. The damage therefore shows up as error counts that keep rising in every following word, and within a few windows as a lost lock. A faulty run or window counter shows up as a lock or unlock one or more words early or late. The stimulus counts words exactly around the 64-bit acquisition run and the 16-error window limit to catch this. Faults in the snapshot or working register appear at the very next tick as a wrong err_last_sec value.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

   localparam int HIST_W = 31;

   typedef enum logic [1:0] {
      POLY_7  = 2'd0,
      POLY_15 = 2'd1,
      POLY_23 = 2'd2,
      POLY_31 = 2'd3
   } prbs_poly_e;

   // index into history (0 = newest bit) of the longer feedback tap
   function automatic logic [4:0] tap_far(input prbs_poly_e p);
      case (p)
         POLY_7:  return 5'd6;
         POLY_15: return 5'd14;
         POLY_23: return 5'd22;
         default: return 5'd30;
      endcase
   endfunction

   // index of the shorter feedback tap
   function automatic logic [4:0] tap_near(input prbs_poly_e p);
      case (p)
         POLY_7:  return 5'd5;
         POLY_15: return 5'd13;
         POLY_23: return 5'd17;
         default: return 5'd27;
      endcase
   endfunction

endpackage

// File: rtl/prbs_chk_predict.sv
module prbs_chk_predict
   import prbs_chk_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [HIST_W-1:0] hist_q,
   input  logic [W-1:0]      rx_data,
   input  logic              invert,
   input  logic [1:0]        poly_sel,
   input  logic              track,
   output logic [HIST_W-1:0] hist_d,
   output logic [W-1:0]      err_vec
);

   logic [4:0]        far_idx;
   logic [4:0]        near_idx;
   logic [HIST_W-1:0] chain [0:W];

   assign far_idx  = tap_far(prbs_poly_e'(poly_sel));
   assign near_idx = tap_near(prbs_poly_e'(poly_sel));
   assign chain[0] = hist_q;

   // one stage per received bit, earliest bit (MSB) first
   for (genvar i = 0; i < W; i++) begin : g_bit
      localparam int J = W - 1 - i;
      logic pred;
      logic rxb;
      logic shin;
      assign pred        = chain[i][far_idx] ^ chain[i][near_idx];
      assign rxb         = rx_data[J] ^ invert;
      assign err_vec[J]  = pred ^ rxb;
      assign shin        = track ? pred : rxb;
      assign chain[i+1]  = {chain[i][HIST_W-2:0], shin};
   end

   assign hist_d = chain[W];

endmodule

// File: rtl/prbs_chk_sync.sv
module prbs_chk_sync #(
   parameter int W         = 8,
   parameter int LOCK_BITS = 64,
   parameter int WIN_BITS  = 64,
   parameter int LOSS_ERRS = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     valid,
   input  logic [$clog2(W+1)-1:0]   word_errs,
   output logic                     locked
);

   localparam int NW         = $clog2(W + 1);
   localparam int LOCK_WORDS = LOCK_BITS / W;
   localparam int WIN_WORDS  = WIN_BITS / W;
   localparam int RUN_W      = $clog2(LOCK_WORDS + 1);
   localparam int WW         = $clog2(WIN_WORDS + 1);
   localparam int EW         = $clog2(LOSS_ERRS + W + 1);

   if (NW > EW) begin : g_bad_width
      $error("prbs_chk_sync: error-sum width too narrow");
   end

   logic             locked_q;
   logic [RUN_W-1:0] run_q;
   logic [WW-1:0]    win_words_q;
   logic [EW-1:0]    win_errs_q;
   logic [EW-1:0]    err_sum;

   assign err_sum = win_errs_q + EW'(word_errs);
   assign locked  = locked_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_q    <= 1'b0;
         run_q       <= '0;
         win_words_q <= '0;
         win_errs_q  <= '0;
      end else if (valid) begin
         if (!locked_q) begin
            if (word_errs == '0) begin
               if (run_q == RUN_W'(LOCK_WORDS - 1)) begin
                  locked_q    <= 1'b1;
                  run_q       <= '0;
                  win_words_q <= '0;
                  win_errs_q  <= '0;
               end else begin
                  run_q <= run_q + RUN_W'(1);
               end
            end else begin
               run_q <= '0;
            end
         end else begin
            if (err_sum > EW'(LOSS_ERRS)) begin
               locked_q <= 1'b0;
               run_q    <= '0;
            end else if (win_words_q == WW'(WIN_WORDS - 1)) begin
               win_words_q <= '0;
               win_errs_q  <= '0;
            end else begin
               win_words_q <= win_words_q + WW'(1);
               win_errs_q  <= err_sum;
            end
         end
      end
   end

endmodule

// File: rtl/prbs_chk_stats.sv
module prbs_chk_stats #(
   parameter int CNT_W = 32,
   parameter int NW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NW-1:0]    add,
   input  logic             clear,
   input  logic             tick,
   output logic [CNT_W-1:0] total,
   output logic [CNT_W-1:0] last_sec
);

   if (CNT_W < NW) begin : g_bad_cnt
      $error("prbs_chk_stats: CNT_W narrower than per-word error count");
   end

   function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                input logic [NW-1:0]    b);
      logic [CNT_W:0] s;
      s = {1'b0, a} + (CNT_W + 1)'(b);
      return s[CNT_W] ? '1 : s[CNT_W-1:0];
   endfunction

   logic [CNT_W-1:0] total_q;
   logic [CNT_W-1:0] work_q;
   logic [CNT_W-1:0] snap_q;
   logic [CNT_W-1:0] work_plus;

   assign work_plus = sat_add(work_q, add);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         total_q <= '0;
         work_q  <= '0;
         snap_q  <= '0;
      end else begin
         total_q <= sat_add(total_q, add);
         work_q  <= tick ? '0 : work_plus;
         if (tick) snap_q <= work_plus;
      end
   end

   assign total    = total_q;
   assign last_sec = snap_q;

endmodule

// File: rtl/prbs_lane_checker.sv
module prbs_lane_checker
   import prbs_chk_pkg::*;
#(
   parameter int W         = 8,
   parameter int CNT_W     = 32,
   parameter int LOCK_BITS = 64,
   parameter int WIN_BITS  = 64,
   parameter int LOSS_ERRS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     rx_data,
   input  logic             rx_valid,
   input  logic [1:0]       poly_sel,
   input  logic             invert,
   input  logic             clear,
   input  logic             tick_1s,
   output logic             locked,
   output logic [CNT_W-1:0] err_total,
   output logic [CNT_W-1:0] err_last_sec
);

   localparam int NW = $clog2(W + 1);

   if (W < 1 || LOCK_BITS < W || LOCK_BITS % W != 0 || WIN_BITS < W ||
       WIN_BITS % W != 0 || LOSS_ERRS < 1 || LOSS_ERRS >= WIN_BITS) begin : g_bad_cfg
      $error("prbs_lane_checker: inconsistent width, run or window parameters");
   end

   logic [HIST_W-1:0] hist_q;
   logic [HIST_W-1:0] hist_d;
   logic [W-1:0]      err_vec;
   logic [NW-1:0]     word_errs;
   logic [NW-1:0]     cnt_errs;

   prbs_chk_predict #(.W(W)) u_predict (
      .hist_q   (hist_q),
      .rx_data  (rx_data),
      .invert   (invert),
      .poly_sel (poly_sel),
      .track    (locked),
      .hist_d   (hist_d),
      .err_vec  (err_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        hist_q <= '0;
      else if (rx_valid) hist_q <= hist_d;
   end

   always_comb begin
      word_errs = '0;
      for (int k = 0; k < W; k++) word_errs = word_errs + NW'(err_vec[k]);
   end

   assign cnt_errs = (rx_valid && locked) ? word_errs : '0;

   prbs_chk_sync #(
      .W(W), .LOCK_BITS(LOCK_BITS), .WIN_BITS(WIN_BITS), .LOSS_ERRS(LOSS_ERRS)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (rx_valid),
      .word_errs (word_errs),
      .locked    (locked)
   );

   prbs_chk_stats #(.CNT_W(CNT_W), .NW(NW)) u_stats (
      .clk      (clk),
      .rst_n    (rst_n),
      .add      (cnt_errs),
      .clear    (clear),
      .tick     (tick_1s),
      .total    (err_total),
      .last_sec (err_last_sec)
   );

endmodule

// File: rtl/prbs_lane_checker_sva.sv
module prbs_lane_checker_sva #(
   parameter int W     = 8,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             clear,
   input logic             tick_1s,
   input logic             locked,
   input logic [CNT_W-1:0] err_total,
   input logic [CNT_W-1:0] err_last_sec
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   p_unlocked_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && !clear) |=> $stable(err_total));

   p_total_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (err_total >= $past(err_total)) &&
                 ((err_total - $past(err_total)) <= CNT_W'(W)));

   p_snapshot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_1s && !clear) |=> $stable(err_last_sec));

   p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (err_total == '0) && (err_last_sec == '0));

   p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_total == CNT_MAX && !clear) |=> err_total == CNT_MAX);

   p_idle_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(locked));

endmodule

bind prbs_lane_checker prbs_lane_checker_sva #(.W(W), .CNT_W(CNT_W)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_valid     (rx_valid),
   .clear        (clear),
   .tick_1s      (tick_1s),
   .locked       (locked),
   .err_total    (err_total),
   .err_last_sec (err_last_sec)
);

// File: tb/prbs_lane_checker_tb.sv
module prbs_lane_checker_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int CNT_W      = 6;
   localparam int CMAX       = 63;
   localparam int NROWS      = 9;

   // {poly_sel[1:0], data_poly[1:0], data_inv, cfg_inv, words[7:0], exp_lock}
   localparam logic [14:0] TBL [0:NROWS-1] = '{
      {2'd0, 2'd0, 1'b0, 1'b0, 8'd16, 1'b1},
      {2'd1, 2'd1, 1'b0, 1'b0, 8'd16, 1'b1},
      {2'd2, 2'd2, 1'b0, 1'b0, 8'd16, 1'b1},
      {2'd3, 2'd3, 1'b0, 1'b0, 8'd16, 1'b1},
      {2'd0, 2'd0, 1'b0, 1'b0, 8'd7,  1'b0},
      {2'd0, 2'd1, 1'b0, 1'b0, 8'd24, 1'b0},
      {2'd0, 2'd0, 1'b1, 1'b0, 8'd24, 1'b0},
      {2'd0, 2'd0, 1'b1, 1'b1, 8'd16, 1'b1},
      {2'd3, 2'd3, 1'b1, 1'b1, 8'd16, 1'b1}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [W-1:0]     rx_data = '0;
   logic             rx_valid = 1'b0;
   logic [1:0]       poly_sel = 2'd0;
   logic             invert = 1'b0;
   logic             clear = 1'b0;
   logic             tick_1s = 1'b0;
   logic             locked;
   logic [CNT_W-1:0] err_total;
   logic [CNT_W-1:0] err_last_sec;

   int n_checks = 0;
   int n_fail   = 0;
   logic [30:0] gh;

   always #(CLK_PERIOD/2) clk = ~clk;

   prbs_lane_checker #(.W(W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
      .poly_sel(poly_sel), .invert(invert), .clear(clear), .tick_1s(tick_1s),
      .locked(locked), .err_total(err_total), .err_last_sec(err_last_sec)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic gen_word(input logic [1:0] p, output logic [W-1:0] w);
      for (int i = W - 1; i >= 0; i--) begin
         logic b;
         case (p)
            2'd0:    b = gh[6]  ^ gh[5];
            2'd1:    b = gh[14] ^ gh[13];
            2'd2:    b = gh[22] ^ gh[17];
            default: b = gh[30] ^ gh[27];
         endcase
         w[i] = b;
         gh = {gh[29:0], b};
      end
   endtask

   task automatic step(input logic [W-1:0] d, input logic v, input logic tk, input logic clr);
      @(negedge clk);
      rx_data = d; rx_valid = v; tick_1s = tk; clear = clr;
      @(posedge clk);
      #1;
      rx_valid = 1'b0; tick_1s = 1'b0; clear = 1'b0;
   endtask

   task automatic send(input logic [1:0] p, input logic [W-1:0] flips,
                       input logic tk, input logic clr, input logic dinv);
      logic [W-1:0] w;
      gen_word(p, w);
      step(w ^ flips ^ {W{dinv}}, 1'b1, tk, clr);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rx_valid = 1'b0; tick_1s = 1'b0; clear = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      gh = '1;
   endtask

   task automatic acquire(output int n);
      n = 0;
      while (!locked && n < 20) begin
         send(2'd0, '0, 1'b0, 1'b0, 1'b0);
         n++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end

   initial begin
      int n;
      gh = '1;

      // table of acquisition cases: R1 polynomials and run length, R2 polarity
      for (int r = 0; r < NROWS; r++) begin
         logic [14:0] row;
         row = TBL[r];
         do_reset();
         poly_sel = row[14:13];
         invert   = row[9];
         for (int k = 0; k < int'(row[8:1]); k++)
            send(row[12:11], '0, 1'b0, 1'b0, row[10]);
         chk((row[10] || row[9]) ? "R2 lock" : "R1 lock", int'(locked), int'(row[0]));
         chk("R3 no count before lock", int'(err_total), 0);
      end

      // R10 reset state
      do_reset();
      poly_sel = 2'd0; invert = 1'b0;
      #1;
      chk("R10 locked", int'(locked), 0);
      chk("R10 total", int'(err_total), 0);
      chk("R10 last", int'(err_last_sec), 0);

      // R1 acquisition time
      acquire(n);
      chk("R1 locked", int'(locked), 1);
      chk("R1 words to lock in 8..12", int'(n >= 8 && n <= 12), 1);
      chk("R3 total at lock", int'(err_total), 0);

      // R4 exactly 16 errors in a window keeps lock
      for (int k = 0; k < 8; k++) send(2'd0, 8'h81, 1'b0, 1'b0, 1'b0);
      chk("R4 lock kept at limit", int'(locked), 1);
      chk("R3 per-bit count", int'(err_total), 16);

      // R4 seventeenth error in next window drops lock on the sixth word
      for (int k = 0; k < 5; k++) send(2'd0, 8'h92, 1'b0, 1'b0, 1'b0);
      chk("R4 lock before limit", int'(locked), 1);
      send(2'd0, 8'h92, 1'b0, 1'b0, 1'b0);
      chk("R4 lock lost", int'(locked), 0);
      chk("R4 losing word counted", int'(err_total), 34);

      // R3 errors while unlocked ignored
      for (int k = 0; k < 4; k++) send(2'd0, 8'h81, 1'b0, 1'b0, 1'b0);
      chk("R3 unlocked ignored", int'(err_total), 34);

      // R7 clear wins over tick and errors
      send(2'd0, 8'h81, 1'b1, 1'b1, 1'b0);
      chk("R7 total cleared", int'(err_total), 0);
      chk("R7 last cleared", int'(err_last_sec), 0);

      // R5 / R6 accumulation and snapshot
      acquire(n);
      chk("R1 relock", int'(locked), 1);
      send(2'd0, 8'h92, 1'b0, 1'b0, 1'b0);
      chk("R5 total", int'(err_total), 3);
      send(2'd0, 8'h81, 1'b1, 1'b0, 1'b0);
      chk("R6 snapshot includes tick word", int'(err_last_sec), 5);
      chk("R5 total", int'(err_total), 5);
      send(2'd0, 8'h10, 1'b0, 1'b0, 1'b0);
      chk("R6 snapshot held", int'(err_last_sec), 5);
      chk("R5 total", int'(err_total), 6);

      // R9 idle cycles, R6 tick without valid
      step(8'hA5, 1'b0, 1'b1, 1'b0);
      chk("R6 tick without valid", int'(err_last_sec), 1);
      chk("R9 lock kept idle", int'(locked), 1);
      step(8'h3C, 1'b0, 1'b0, 1'b0);
      step(8'hFF, 1'b0, 1'b0, 1'b0);
      chk("R9 total idle", int'(err_total), 6);
      send(2'd0, '0, 1'b1, 1'b0, 1'b0);
      chk("R9 history not advanced", int'(err_total), 6);
      chk("R6 new second", int'(err_last_sec), 0);

      // R8 saturation
      do_reset();
      acquire(n);
      for (int k = 0; k < 31; k++) send(2'd0, 8'h81, 1'b0, 1'b0, 1'b0);
      send(2'd0, 8'h81, 1'b1, 1'b0, 1'b0);
      chk("R8 locked", int'(locked), 1);
      chk("R8 total saturated", int'(err_total), CMAX);
      chk("R8 last saturated", int'(err_last_sec), CMAX);
      send(2'd0, 8'h81, 1'b0, 1'b0, 1'b0);
      chk("R8 total stays", int'(err_total), CMAX);
      send(2'd0, 8'h81, 1'b1, 1'b1, 1'b0);
      chk("R7 clear over tick", int'(err_last_sec), 0);
      chk("R7 lock unaffected", int'(locked), 1);

      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end

endmodule